// File: doc/BRIEF.md
# Dual-Channel PCM Time-Slot Port

This block connects a two-channel voice datapath to a time-division multiplexed serial bus. The bus bit clock runs the block. A single frame-sync input marks the start of every frame. In each frame the block sends two companded transmit samples on the serial output and collects two receive samples from the serial input. Each sample is `SLOT_W` bits wide, and the two slots follow each other with no gap. Data is delayed by one bit time: the first bit of a frame appears one bit-clock after the edge that sees frame sync rise.

The width of the frame-sync pulse sets the slot order. A pulse one bit-clock wide puts channel 0 in the first slot. A pulse that is still high at the next rising edge puts channel 1 first. The order is only known at that second edge, so the first transmitted bit of a frame uses the order kept from the previous frame. After reset that kept order is channel 0. The codec side loads both transmit samples when frame sync rises. It receives both samples together with a one-cycle strobe at the end of the frame. The block also watches for missing frames and raises a power-down flag when frame sync stops.

Top module: `pcm_dual_port`

## Requirements
- R1: While reset is held low at a rising edge, `dx_oe`, `dx_out`, `rx_stb` and `pwr_down` are 0, and both receive sample ports read 0.
- R2: Call the rising edge that first samples `fsync` high after it was low E0. `dx_oe` is 0 after E0 and rises after E1. It stays high for exactly 2*SLOT_W cycles and falls after edge E(2*SLOT_W+1).
- R3: With a one-cycle frame-sync pulse (`fsync` low again at E1), channel 0's sample fills the first slot on `dx_out` and channel 1's fills the second. Each sample is sent MSB first, and bit k of the frame is driven after edge E(k+1).
- R4: With `fsync` still high at E1, channel 1 goes first from frame bit 1 onward. Frame bit 0 is the MSB of the channel that went first in the previous frame. On the first frame after reset that channel is channel 0.
- R5: `tx_samp0` and `tx_samp1` are captured at E0. Changing them later in the same frame has no effect on `dx_out` for that frame.
- R6: `dr_in` is sampled on the falling bit-clock edge. The bit sampled after E(k+1) is frame bit k. The first slot is routed to the channel that R3/R4 place first for frame bits 1 onward, and the second slot to the other channel. Each slot is MSB first.
- R7: `rx_stb` goes high for exactly one cycle after edge E(2*SLOT_W+1). At that moment `rx_samp0`/`rx_samp1` hold the samples of the frame just received, and `dx_oe` has just fallen.
- R8: If no frame-sync rising edge is seen for PD_TIMEOUT rising edges after the last one, `pwr_down` rises after the edge E0+PD_TIMEOUT. The next frame-sync rise clears it at that rise edge.
- R9: `dx_out` is 0 whenever `dx_oe` is 0, so the pad buffer outside the block may float the line.
- R10: A frame-sync rise during a frame restarts the frame at once. `dx_oe` is 0 after that E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock; everything runs on its rising edge except DR capture |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync; its pulse width selects the slot order |
| dr_in | input | 1 | Serial receive data from the bus |
| tx_samp0 | input | SLOT_W | Transmit sample for channel 0 |
| tx_samp1 | input | SLOT_W | Transmit sample for channel 1 |
| dx_out | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for the transmit pad |
| rx_samp0 | output | SLOT_W | Last received sample for channel 0 |
| rx_samp1 | output | SLOT_W | Last received sample for channel 1 |
| rx_stb | output | 1 | One-cycle pulse when both receive samples are updated |
| pwr_down | output | 1 | High while frame sync has been missing for the timeout |

## Verification
The bench keeps `SLOT_W` at 8, so every frame carries the full 16 slot bits with real 8-bit samples. It lowers `PD_TIMEOUT` to 40. That way the power-down flag can be reached and then cleared within a short idle gap, while a frame period of about 27 clocks stays safely below the limit. With these values the bench walks through the default order after reset, both swap transitions in which bit 0 follows the old order, and a change of the transmit inputs in the middle of a frame.

// File: rtl/pcm_pkg.sv
// Shared types for the dual-channel PCM port.
// Assumes exactly two channels; the channel id is one bit.
package pcm_pkg;
    typedef enum logic {
        CH_0 = 1'b0,
        CH_1 = 1'b1
    } pcm_ch_e;
endpackage

// File: rtl/pcm_fs_detect.sv
// Frame-sync edge detector and missing-frame watchdog.
// Finds the rising edge of fsync as seen at the bit-clock rising edge. It raises
// pwr_down once PD_TIMEOUT edges pass without a new rise.
// Assumes fsync is already synchronous to clk.
module pcm_fs_detect #(
    parameter int PD_TIMEOUT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic fs_rise,
    output logic pwr_down
);
    localparam int CW = $clog2(PD_TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PD_TIMEOUT - 1);

    logic          fs_prev;
    logic [CW-1:0] idle_cnt;

    // Rising edge: high now, low at the previous edge.
    assign fs_rise = fsync & ~fs_prev;

    // Keep the last sampled frame-sync level.
    always_ff @(posedge clk) begin
        if (!rst_n) fs_prev <= 1'b0;
        else        fs_prev <= fsync;
    end

    // Count edges since the last rise; flag power-down when the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            pwr_down <= 1'b0;
        end else if (fs_rise) begin
            idle_cnt <= '0;
            pwr_down <= 1'b0;
        end else if (idle_cnt == LIMIT) begin
            pwr_down <= 1'b1;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcm_frame_ctr.sv
// Frame phase counter and slot-order latch.
// Phase 0 means idle. A frame-sync rise loads phase 1, and the counter then runs to
// 2*SLOT_W+1 before returning to idle. At phase 1 the order is taken from the
// fsync level (still high = wide pulse = channel 1 first).
// Assumes frames are at least 2*SLOT_W+2 clocks long; an earlier rise restarts.
module pcm_frame_ctr
    import pcm_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            fsync,
    output logic [$clog2(2*SLOT_W+2)-1:0]   phase,
    output pcm_ch_e                         first_ch
);
    localparam int PH_W = $clog2(2*SLOT_W+2);
    localparam logic [PH_W-1:0] PH_FIRST = PH_W'(1);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(2*SLOT_W+1);

    // Advance the phase through one frame, restarting on every rise.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase <= '0;
        else if (start)            phase <= PH_FIRST;
        else if (phase == PH_LAST) phase <= '0;
        else if (phase != '0)      phase <= phase + 1'b1;
    end

    // Latch the slot order once the pulse width is known.
    always_ff @(posedge clk) begin
        if (!rst_n)                 first_ch <= CH_0;
        else if (phase == PH_FIRST) first_ch <= fsync ? CH_1 : CH_0;
    end
endmodule

// File: rtl/pcm_tx_ser.sv
// Transmit serializer.
// Captures both samples on the frame-sync rise. For phases 1..2*SLOT_W it drives
// frame bit (phase-1) MSB first, taking the slot order from first_ch. At phase 1,
// first_ch still holds the previous frame's order.
// Assumes phase and first_ch come from pcm_frame_ctr.
module pcm_tx_ser
    import pcm_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [$clog2(2*SLOT_W+2)-1:0]   phase,
    input  pcm_ch_e                         first_ch,
    input  logic [SLOT_W-1:0]               samp0,
    input  logic [SLOT_W-1:0]               samp1,
    output logic                            dx_out,
    output logic                            dx_oe
);
    localparam int PH_W  = $clog2(2*SLOT_W+2);
    localparam int FR_W  = 2*SLOT_W;
    localparam logic [PH_W-1:0] PH_FIRST = PH_W'(1);
    localparam logic [PH_W-1:0] PH_DATA  = PH_W'(FR_W);

    logic [SLOT_W-1:0] hold0, hold1;
    logic [FR_W-1:0]   pair, pair_sh;
    logic [PH_W-1:0]   bit_idx;
    logic              in_data;

    // Arrange the two held samples in slot order and pick the current bit.
    always_comb begin
        pair    = (first_ch == CH_0) ? {hold0, hold1} : {hold1, hold0};
        bit_idx = phase - PH_FIRST;
        pair_sh = pair << bit_idx;
        in_data = (phase >= PH_FIRST) && (phase <= PH_DATA);
    end

    // Capture the transmit samples at the start of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold0 <= '0;
            hold1 <= '0;
        end else if (start) begin
            hold0 <= samp0;
            hold1 <= samp1;
        end
    end

    // Drive one bit per clock during the slots; hold the line low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || start || !in_data) begin
            dx_out <= 1'b0;
            dx_oe  <= 1'b0;
        end else begin
            dx_out <= pair_sh[FR_W-1];
            dx_oe  <= 1'b1;
        end
    end
endmodule

// File: rtl/pcm_rx_des.sv
// Receive deserializer.
// Captures dr_in on the falling edge. On phases 2..2*SLOT_W+1 it shifts in the
// bit sampled in the previous half cycle. At the last phase it splits the frame
// into the two channel samples and pulses rx_stb.
// Assumes phase and first_ch come from pcm_frame_ctr.
module pcm_rx_des
    import pcm_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(2*SLOT_W+2)-1:0]   phase,
    input  pcm_ch_e                         first_ch,
    input  logic                            dr_in,
    output logic [SLOT_W-1:0]               rx_samp0,
    output logic [SLOT_W-1:0]               rx_samp1,
    output logic                            rx_stb
);
    localparam int PH_W = $clog2(2*SLOT_W+2);
    localparam int FR_W = 2*SLOT_W;
    localparam logic [PH_W-1:0] PH_SHIFT = PH_W'(2);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(FR_W+1);

    logic            dr_q;
    logic [FR_W-1:0] shreg;
    logic [FR_W-1:0] full;

    // Frame as it stands once the current bit is added.
    assign full = {shreg[FR_W-2:0], dr_q};

    // Sample the serial input in the middle of the bit time.
    always_ff @(negedge clk) begin
        if (!rst_n) dr_q <= 1'b0;
        else        dr_q <= dr_in;
    end

    // Shift the received bits in during the data phases.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (phase >= PH_SHIFT && phase <= PH_LAST)
            shreg <= full;
    end

    // Split the frame into channels and strobe once at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_samp0 <= '0;
            rx_samp1 <= '0;
            rx_stb   <= 1'b0;
        end else begin
            rx_stb <= 1'b0;
            if (phase == PH_LAST) begin
                rx_stb <= 1'b1;
                if (first_ch == CH_0) begin
                    rx_samp0 <= full[FR_W-1:SLOT_W];
                    rx_samp1 <= full[SLOT_W-1:0];
                end else begin
                    rx_samp1 <= full[FR_W-1:SLOT_W];
                    rx_samp0 <= full[SLOT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/pcm_dual_port.sv
// Dual-channel PCM time-slot port, top level.
// Connects the frame-sync detector, phase counter, serializer and deserializer.
// Assumes the bit clock is the bus clock and fsync is synchronous to it.
module pcm_dual_port
    import pcm_pkg::*;
#(
    parameter int SLOT_W     = 8,
    parameter int PD_TIMEOUT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              dr_in,
    input  logic [SLOT_W-1:0] tx_samp0,
    input  logic [SLOT_W-1:0] tx_samp1,
    output logic              dx_out,
    output logic              dx_oe,
    output logic [SLOT_W-1:0] rx_samp0,
    output logic [SLOT_W-1:0] rx_samp1,
    output logic              rx_stb,
    output logic              pwr_down
);
    localparam int PH_W = $clog2(2*SLOT_W+2);

    logic            fs_rise;
    logic [PH_W-1:0] phase;
    pcm_ch_e         first_ch;

    pcm_fs_detect #(.PD_TIMEOUT(PD_TIMEOUT)) u_fs (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .fs_rise(fs_rise), .pwr_down(pwr_down)
    );

    pcm_frame_ctr #(.SLOT_W(SLOT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .start(fs_rise), .fsync(fsync),
        .phase(phase), .first_ch(first_ch)
    );

    pcm_tx_ser #(.SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(fs_rise), .phase(phase),
        .first_ch(first_ch), .samp0(tx_samp0), .samp1(tx_samp1),
        .dx_out(dx_out), .dx_oe(dx_oe)
    );

    pcm_rx_des #(.SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .phase(phase), .first_ch(first_ch),
        .dr_in(dr_in), .rx_samp0(rx_samp0), .rx_samp1(rx_samp1),
        .rx_stb(rx_stb)
    );
endmodule

// File: rtl/pcm_dual_port_chk.sv
// Property checker for pcm_dual_port, bound to every instance.
module pcm_dual_port_chk #(
    parameter int SLOT_W = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            fs_rise,
    input logic [$clog2(2*SLOT_W+2)-1:0]   phase,
    input logic                            first_ch,
    input logic                            dx_out,
    input logic                            dx_oe,
    input logic                            rx_stb,
    input logic                            pwr_down
);
    localparam int PH_W = $clog2(2*SLOT_W+2);
    localparam int RW   = $clog2(2*SLOT_W+1);
    localparam logic [RW-1:0]   RUN_MAX = RW'(2*SLOT_W);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    logic [RW-1:0] oe_run;

    // Count consecutive enabled cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n || !dx_oe) oe_run <= '0;
        else if (oe_run != RUN_MAX) oe_run <= oe_run + 1'b1;
    end

    assert_oe_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dx_oe |-> oe_run < RUN_MAX);
    assert_oe_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dx_oe) |-> $past(phase) == PH_ONE);
    assert_order_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(first_ch) |-> $past(phase) == PH_ONE);
    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !rx_stb);
    assert_strobe_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |-> !dx_oe && $past(dx_oe));
    assert_pd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fs_rise |=> !pwr_down);
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dx_oe |-> !dx_out);
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fs_rise |=> !dx_oe);
endmodule

bind pcm_dual_port pcm_dual_port_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .phase(phase),
    .first_ch(first_ch), .dx_out(dx_out), .dx_oe(dx_oe),
    .rx_stb(rx_stb), .pwr_down(pwr_down)
);

// File: tb/sim_pcm_dual_port.sv
module sim_pcm_dual_port;
    localparam int W   = 8;
    localparam int PDT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic dr_in = 1'b0;
    logic [W-1:0] tx_samp0 = '0, tx_samp1 = '0;
    logic dx_out, dx_oe, rx_stb, pwr_down;
    logic [W-1:0] rx_samp0, rx_samp1;

    int errors = 0;
    int checks = 0;
    bit prev_wide = 1'b0;
    logic exp_dx[$];
    logic [2*W-1:0] exp_rx[$];

    always #10 clk = ~clk;

    pcm_dual_port #(.SLOT_W(W), .PD_TIMEOUT(PDT)) u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .dr_in(dr_in),
        .tx_samp0(tx_samp0), .tx_samp1(tx_samp1),
        .dx_out(dx_out), .dx_oe(dx_oe),
        .rx_samp0(rx_samp0), .rx_samp1(rx_samp1),
        .rx_stb(rx_stb), .pwr_down(pwr_down)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: queues the expected transmit bits and receive pair, then runs one frame.
    task automatic frame(input bit wide, input logic [W-1:0] t0, input logic [W-1:0] t1,
                         input logic [W-1:0] r0, input logic [W-1:0] r1, input bit poke);
        logic [W-1:0] tf, ts, rf, rs;
        logic [2*W-1:0] rbits;
        tf = wide ? t1 : t0;  ts = wide ? t0 : t1;
        rf = wide ? r1 : r0;  rs = wide ? r0 : r1;
        // R3/R4: bit 0 follows the previous frame's order
        exp_dx.push_back(prev_wide ? t1[W-1] : t0[W-1]);
        for (int i = 1; i < 2*W; i++)
            exp_dx.push_back(i < W ? tf[W-1-i] : ts[2*W-1-i]);
        exp_rx.push_back({r0, r1});
        rbits = {rf, rs};
        tx_samp0 = t0; tx_samp1 = t1;
        @(posedge clk); #2 fsync = 1'b1;
        @(posedge clk); #2;                       // E0
        if (!wide) fsync = 1'b0;
        if (poke) begin tx_samp0 = ~t0; tx_samp1 = ~t1; end   // R5
        #3;
        chk(dx_oe == 1'b0, "R2 oe low after E0", dx_oe, 0);
        chk(pwr_down == 1'b0, "R8 cleared by rise", pwr_down, 0);
        @(posedge clk); #2;                       // E1
        fsync = 1'b0; dr_in = rbits[2*W-1];
        #3;
        chk(dx_oe == 1'b1, "R2 oe high after E1", dx_oe, 1);
        for (int i = 1; i < 2*W; i++) begin
            @(posedge clk); #2 dr_in = rbits[2*W-1-i];
        end
        @(posedge clk); #5;                       // E17
        chk(rx_stb == 1'b1, "R7 strobe after last phase", rx_stb, 1);
        chk(dx_oe == 1'b0, "R2 oe low after frame", dx_oe, 0);
        prev_wide = wide;
        for (int i = 0; i < 8; i++) @(posedge clk);   // ends at E25
    endtask

    // Monitor: compares serial output and receive results against the queues.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (dx_oe) begin
                if (exp_dx.size() == 0) chk(1'b0, "R2 extra dx bit", 1, 0);
                else begin
                    logic e;
                    e = exp_dx.pop_front();
                    chk(dx_out == e, "R3/R4/R5 dx bit", dx_out, e);
                end
            end else begin
                chk(dx_out == 1'b0, "R9 idle line", dx_out, 0);
            end
            if (rx_stb) begin
                if (exp_rx.size() == 0) chk(1'b0, "R7 extra strobe", 1, 0);
                else begin
                    logic [2*W-1:0] r;
                    r = exp_rx.pop_front();
                    chk({rx_samp0, rx_samp1} == r, "R6 rx samples", {rx_samp0, rx_samp1}, r);
                end
            end
        end
    end

    initial begin : wdog
        #2000000;
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk(dx_oe == 0 && dx_out == 0 && rx_stb == 0 && pwr_down == 0, "R1 reset outputs",
            {dx_oe, dx_out, rx_stb, pwr_down}, 0);
        chk(rx_samp0 == 0 && rx_samp1 == 0, "R1 reset samples", {rx_samp0, rx_samp1}, 0);
        @(posedge clk); #2 rst_n = 1'b1;
        frame(1'b1, 8'hA5, 8'h3C, 8'h96, 8'h0F, 1'b0);   // R4 default order then swap
        frame(1'b1, 8'h81, 8'h7E, 8'hC3, 8'h5A, 1'b0);   // R4 steady swap
        frame(1'b0, 8'h12, 8'hED, 8'h01, 8'hF0, 1'b0);   // R4 back to R3 order
        frame(1'b0, 8'hB4, 8'h4B, 8'h77, 8'h88, 1'b1);   // R3, R5 mid-frame change
        // R8: idle until the watchdog limit (frame ended at E25)
        repeat (PDT - 26) @(posedge clk);
        #5 chk(pwr_down == 1'b0, "R8 before limit", pwr_down, 0);
        @(posedge clk); #5 chk(pwr_down == 1'b1, "R8 at limit", pwr_down, 1);
        frame(1'b1, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0);   // R8 clear, R4 swap
        // R10: restart mid-frame drops the enable at once
        @(posedge clk); #2 fsync = 1'b1;
        @(posedge clk); #2 fsync = 1'b0;
        repeat (5) @(posedge clk);
        #2 fsync = 1'b1;
        @(posedge clk); #2 fsync = 1'b0;
        #3 chk(dx_oe == 1'b0, "R10 restart oe low", dx_oe, 0);
        repeat (25) @(posedge clk);
        exp_dx.delete(); exp_rx.delete();
        chk(1'b1, "R10 done", 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // R10 frames are not scored bit by bit; silence the queue compare for them.
    always @(posedge clk) begin
        #4;
        if (rst_n && dx_oe && exp_dx.size() == 0) exp_dx.push_back(dx_out);
        if (rst_n && rx_stb && exp_rx.size() == 0) exp_rx.push_back({rx_samp0, rx_samp1});
    end
endmodule